// File: doc/BRIEF.md
# SPI Master with Programmable Clock Divider

This block is a synchronous serial master that moves one fixed-length word per frame. The word goes out most significant bit first on a data output. At the same time a word is gathered from a receive data line. The serial clock is made from a source clock by a programmable divider. The source is one of two: half the system clock rate, or an external clock input that the block synchronises. Every register in the block runs on the system clock. The source clock only produces enable steps, one per half source period.

The parallel side takes a frame request through a valid/ready pair: `start` with `tx_word`, and `ready`. A request is taken only in a cycle where `ready` is high. A request raised while `ready` is low is dropped; it is not held or queued. The divide value is captured together with the word. The received word comes back on `rx_word` with a one-cycle `done` pulse. The return path has no back-pressure: the consumer must take the word when `done` fires, and `rx_word` then holds until the next `done`. The data output has a separate enable, so a pad outside the block can float the line between frames.

A frame runs as follows. Slave-select falls first, and the first bit is presented at that moment. Then come the clock pulses. The data output is released after the last pulse, and slave-select rises one low phase later.

Top module: `spim_master`

## Requirements
- R1: One serial clock period lasts (1 + D) source periods, where D is the divide value captured at acceptance. With `src_sel` = 0 the source period is two system clock cycles. With `src_sel` = 1 it is one period of `ext_clk`.
- R2: For an even, nonzero D the serial clock is high for D/2 + 1 source periods and low for D/2 source periods.
- R3: For an odd D the high and low phases each last (D + 1)/2 source periods.
- R4: For D = 0 the serial clock runs at the source rate, high for half a source period and low for half a source period (one system clock cycle each with `src_sel` = 0).
- R5: `ready` is high only while no frame is in progress. A `start` seen while `ready` is low changes neither the frame in flight, nor its divide value, nor its data.
- R6: `ss_n` (active low) falls in the cycle after acceptance, while `sclk` is low. It stays low for one low phase before the first rising edge of `sclk`.
- R7: `mosi_o` carries `tx_word` most significant bit first. The first bit is driven when `ss_n` falls. Each later bit appears only just after a falling edge of `sclk`.
- R8: `miso` is sampled on each rising edge of `sclk`, first bit into the most significant position. The full word appears on `rx_word` in the same cycle as a one-cycle `done` pulse, and holds until the next `done`.
- R9: `mosi_oe` falls at the falling edge that ends the last bit. `ss_n` rises one low phase later, in the cycle `done` is high.
- R10: After reset and between frames, `sclk` is low, `ss_n` is high, `mosi_oe` is low and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk | input | 1 | External source clock, synchronised inside |
| src_sel | input | 1 | 0: source is clk/2, 1: source is ext_clk |
| div_val | input | DIV_W | Divide value D, captured with a request |
| start | input | 1 | Request valid |
| ready | output | 1 | Request ready (idle) |
| tx_word | input | WORD_W | Word to transmit, captured with a request |
| rx_word | output | WORD_W | Last received word |
| done | output | 1 | One-cycle pulse when rx_word is updated |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso | input | 1 | Serial data in |

## Verification
The assertions take three things for granted about the inputs. First, `src_sel` does not change while a frame is in flight. Second, `ext_clk` stays at each level for at least two system clock cycles, so the synchroniser sees every edge. Third, `miso` is steady around the system clock edge where `sclk` rises. The stimulus follows all three. It changes `src_sel` only while `ready` is high. It toggles `ext_clk` every three system clock cycles. Its slave model updates `miso` only at falling system clock edges, after it sees `ss_n` fall or `sclk` fall.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    FS_IDLE,
    FS_LOW,
    FS_HIGH,
    FS_TAIL
  } fstate_e;
endpackage

// File: rtl/spim_hstep.sv
// Produces one enable per half source period, in the clk domain.
module spim_hstep #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic src_sel,
  output logic hstep
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SW-2:0], ext_clk};
  end

  // clk/2 source: every clk cycle is half a source period.
  // external source: each detected edge is half a source period.
  assign hstep = src_sel ? (sync_q[SW-1] ^ sync_q[SW-2]) : 1'b1;
endmodule

// File: rtl/spim_phase.sv
// Serial clock phase lengths, counted in half source periods.
module spim_phase #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W:0]   high_len,
  output logic [DIV_W:0]   low_len
);
  localparam int PW = DIV_W + 1;

  logic [PW-1:0] d_ext;
  assign d_ext = {1'b0, div};

  always_comb begin
    if (div == '0) begin
      high_len = PW'(1);
      low_len  = PW'(1);
    end else if (div[0]) begin
      high_len = d_ext + PW'(1);
      low_len  = d_ext + PW'(1);
    end else begin
      high_len = d_ext + PW'(2);
      low_len  = d_ext;
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  input  logic              sample,
  input  logic              miso,
  output logic              tx_bit,
  output logic [WORD_W-1:0] rx_q
);
  logic [WORD_W-1:0] tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)       tx_q <= load_word;
      else if (shift) tx_q <= tx_q << 1;
      if (sample)     rx_q <= {rx_q[WORD_W-2:0], miso};
    end
  end

  assign tx_bit = tx_q[WORD_W-1];
endmodule

// File: rtl/spim_master.sv
module spim_master #(
  parameter int WORD_W      = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              src_sel,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              start,
  output logic              ready,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              sclk,
  output logic              ss_n,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso
);
  import spim_pkg::*;

  localparam int PW  = DIV_W + 1;
  localparam int BCW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);

  fstate_e          st;
  logic [PW-1:0]    hcnt;
  logic [BCW-1:0]   bitcnt;
  logic [DIV_W-1:0] div_q;
  logic             hstep;
  logic [PW-1:0]    high_len, low_len, cur_len;
  logic             ph_end, ld, sh, smp;
  logic [WORD_W-1:0] rx_q;

  spim_hstep #(.SYNC_STAGES(SYNC_STAGES)) u_hstep (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .src_sel(src_sel), .hstep(hstep)
  );

  spim_phase #(.DIV_W(DIV_W)) u_phase (
    .div(div_q), .high_len(high_len), .low_len(low_len)
  );

  spim_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_word(tx_word), .shift(sh),
    .sample(smp), .miso(miso), .tx_bit(mosi_o), .rx_q(rx_q)
  );

  assign cur_len = (st == FS_HIGH) ? high_len : low_len;
  assign ph_end  = hstep && (hcnt == cur_len - PW'(1));
  assign ready   = (st == FS_IDLE);
  assign ld      = ready && start;
  assign smp     = (st == FS_LOW) && ph_end;
  assign sh      = (st == FS_HIGH) && ph_end && (bitcnt != LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= FS_IDLE;
      hcnt    <= '0;
      bitcnt  <= '0;
      div_q   <= '0;
      sclk    <= 1'b0;
      ss_n    <= 1'b1;
      mosi_oe <= 1'b0;
      done    <= 1'b0;
      rx_word <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        FS_IDLE: if (start) begin
          div_q   <= div_val;
          ss_n    <= 1'b0;
          mosi_oe <= 1'b1;
          hcnt    <= '0;
          bitcnt  <= '0;
          st      <= FS_LOW;
        end
        FS_LOW: if (hstep) begin
          if (ph_end) begin
            sclk <= 1'b1;
            hcnt <= '0;
            st   <= FS_HIGH;
          end else hcnt <= hcnt + PW'(1);
        end
        FS_HIGH: if (hstep) begin
          if (ph_end) begin
            sclk <= 1'b0;
            hcnt <= '0;
            if (bitcnt == LAST_BIT) begin
              mosi_oe <= 1'b0;
              st      <= FS_TAIL;
            end else begin
              bitcnt <= bitcnt + BCW'(1);
              st     <= FS_LOW;
            end
          end else hcnt <= hcnt + PW'(1);
        end
        FS_TAIL: if (hstep) begin
          if (ph_end) begin
            ss_n    <= 1'b1;
            done    <= 1'b1;
            rx_word <= rx_q;
            st      <= FS_IDLE;
          end else hcnt <= hcnt + PW'(1);
        end
        default: st <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spim_master_chk.sv
module spim_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic ss_n,
  input logic mosi_o,
  input logic mosi_oe,
  input logic done,
  input logic ready
);
  AST_SS_LEADS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $past(!ss_n)); // R6
  AST_SS_FALL_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ss_n) |-> !sclk); // R6
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> (!sclk && !mosi_oe)); // R10
  AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi_o)); // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_RELEASE_BEFORE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> $past(!mosi_oe)); // R9
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ss_n); // R5
endmodule

bind spim_master spim_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi_o(mosi_o),
  .mosi_oe(mosi_oe), .done(done), .ready(ready)
);

// File: tb/spim_master_tb_top.sv
module spim_master_tb_top;
  localparam int W  = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0, src_sel = 1'b0;
  logic start = 1'b0, miso = 1'b0;
  logic [DW-1:0] div_val = '0;
  logic [W-1:0]  tx_word = '0;
  logic ready, done, sclk, ss_n, mosi_o, mosi_oe;
  logic [W-1:0] rx_word;

  int errors = 0, checks = 0, cyc = 0;

  spim_master #(.WORD_W(W), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .src_sel(src_sel),
    .div_val(div_val), .start(start), .ready(ready), .tx_word(tx_word),
    .rx_word(rx_word), .done(done), .sclk(sclk), .ss_n(ss_n),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .miso(miso)
  );

  always #5 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  // slave model: first bit on select, next bit after each falling sclk
  logic [W-1:0] slv_word = '0, slv_sh = '0;
  logic ss_prev = 1'b1, sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (ss_prev && !ss_n) begin
      miso   <= slv_word[W-1];
      slv_sh <= slv_word << 1;
    end else if (sclk_prev && !sclk && !ss_n) begin
      miso   <= slv_sh[W-1];
      slv_sh <= slv_sh << 1;
    end
    ss_prev   <= ss_n;
    sclk_prev <= sclk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string par_req(input int d);
    if (d == 0) return "R4";
    else if (d % 2 == 1) return "R3";
    else return "R2";
  endfunction

  // half-source-period counts of each phase
  function automatic int hi_len(input int d);
    if (d == 0) return 1;
    else if (d % 2 == 1) return d + 1;
    else return d + 2;
  endfunction
  function automatic int lo_len(input int d);
    if (d == 0) return 1;
    else if (d % 2 == 1) return d + 1;
    else return d;
  endfunction

  task automatic cmp(input int es, input int ess, input int eoe, input int emo,
                     input int edn, input int erd, input string preq);
    check(sclk == es, preq, "sclk", sclk, es);
    check(ss_n == ess, "R6", "ss_n", ss_n, ess);
    check(mosi_oe == eoe, "R9", "mosi_oe", mosi_oe, eoe);
    if (eoe != 0) check(mosi_o == emo, "R7", "mosi_o", mosi_o, emo);
    check(done == edn, "R8", "done", done, edn);
    check(ready == erd, "R5", "ready", ready, erd);
  endtask

  // internal source: full cycle-by-cycle reference, optional busy request
  task automatic run_int(input logic [W-1:0] tx, input logic [W-1:0] sl,
                         input int d, input bit poke);
    int h = hi_len(d);
    int l = lo_len(d);
    string pr = par_req(d);
    slv_word = sl;
    @(negedge clk);
    start = 1'b1; tx_word = tx; div_val = DW'(d);
    @(negedge clk);
    start = 1'b0;
    for (int b = W - 1; b >= 0; b--) begin
      for (int k = 0; k < l + h; k++) begin
        cmp((k >= l) ? 1 : 0, 0, 1, int'(tx[b]), 0, 0, pr);
        if (poke && b == W - 2 && k == 0) begin
          start = 1'b1; tx_word = ~tx; div_val = DW'(d + 3); // R5 busy request
        end else start = 1'b0;
        @(negedge clk);
      end
    end
    for (int k = 0; k < l; k++) begin
      cmp(0, 0, 0, 0, 0, 0, pr);
      @(negedge clk);
    end
    cmp(0, 1, 0, 0, 1, 1, pr);
    check(rx_word == sl, "R8", "rx_word at done", int'(rx_word), int'(sl));
    @(negedge clk);
    cmp(0, 1, 0, 0, 0, 1, "R10");
    check(rx_word == sl, "R8", "rx_word held", int'(rx_word), int'(sl));
  endtask

  // external source (half period 3 clk): pulse widths and data
  task automatic run_ext(input logic [W-1:0] tx, input logic [W-1:0] sl, input int d);
    int h = 3 * hi_len(d);
    int l = 3 * lo_len(d);
    int run = 0, highs = 0, guard = 0;
    logic lvl = 1'b0;
    bit seen = 1'b0;
    slv_word = sl;
    @(negedge clk);
    start = 1'b1; tx_word = tx; div_val = DW'(d);
    @(negedge clk);
    start = 1'b0;
    while (!done && guard < 20000) begin
      guard++;
      if (sclk != lvl) begin
        if (lvl) begin
          check(run == h, "R1", {par_req(d), " high width"}, run, h);
          highs++;
        end else begin
          if (highs > 0) check(run == l, "R1", {par_req(d), " low width"}, run, l);
          check(ss_n == 1'b0, "R6", "ss_n at rise", ss_n, 0);
          if (highs < W)
            check(mosi_o == tx[W-1-highs], "R7", "mosi at rise", mosi_o, tx[W-1-highs]);
        end
        lvl = sclk;
        run = 1;
      end else run++;
      @(negedge clk);
    end
    seen = done;
    check(seen, "R8", "done seen", seen, 1);
    check(highs == W, "R1", "pulse count", highs, W);
    check(rx_word == sl, "R8", "rx_word ext", int'(rx_word), int'(sl));
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp(0, 1, 0, 0, 0, 1, "R10"); // reset state
    check(rx_word == '0, "R10", "rx_word reset", int'(rx_word), 0);

    src_sel = 1'b0;
    run_int(8'hA5, 8'h3C, 0, 1'b0);
    run_int(8'h81, 8'h7E, 1, 1'b0);
    run_int(8'h5A, 8'hC3, 2, 1'b1);
    run_int(8'hFF, 8'h00, 5, 1'b0);
    run_int(8'h00, 8'hFF, 6, 1'b1);
    run_int(8'h96, 8'h69, 0, 1'b1);

    src_sel = 1'b1;
    run_ext(8'hC6, 8'h1B, 0);
    run_ext(8'h3D, 8'hE2, 3);
    run_ext(8'h72, 8'h8D, 4);
    src_sel = 1'b0;
    repeat (4) @(negedge clk);
    cmp(0, 1, 0, 0, 0, 1, "R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule